// File: doc/BRIEF.md
# Event Timer with Shadowed Compare Registers

This block is a 16-bit up-counting timer and event counter. Its count clock is one of three prescaler tap enables, at divide by 1, 4 and 16 of the timer base clock, or an external event line. The block synchronizes that line and counts each of its rising edges. Two compare channels each hold an active compare value and a shadow buffer. Each channel raises a one-cycle match pulse on the count tick where the counter equals its active value. Channel 1 can also reset the counter, which makes the block a period timer. An overflow pulse marks the wrap from the all-ones count to zero.

Software controls the block through a small register port. A control word sets run, a one-shot clear, the clock source, clear-on-match and shadow buffering. A compare value can be written as one full-width write, or as a low-part write followed by a high-part write. With buffering off, a compare write takes effect at once. With buffering on, the write only fills the shadow buffer. The active value then takes the buffer content on the next tick where the counter matches it, so a running period can be changed without a glitch. A combinational read port returns the control word, either active compare value or the live count.

Top module: `evt_timer16`

## Requirements
- R1: The counter is CNT_W (16) bits wide, counts only upward and advances by exactly one on each count tick. Without clear-on-match it wraps from 0xFFFF to 0x0000. Between ticks it holds its value.
- R2: Control bits [3:2] select the count source: 0 is `tap_div1`, 1 is `tap_div4`, 2 is `tap_div16`, 3 is the external event. A tick happens only when control bit 0 (run) is 1 and the selected source is high at a clock edge.
- R3: `ext_evt` passes through a two-flop synchronizer and a rising-edge detector. Each low-to-high transition gives exactly one tick, however long the level stays high.
- R4: With run at 0 the count holds. A control write (address 0) with bit 1 set forces the count to 0 at that edge. This clear beats a simultaneous tick, and that tick produces no match or overflow pulse. Bit 1 reads back as 0.
- R5: When control bit 4 (clear-on-match) is 1, a tick at which the count equals active compare 1 loads 0 instead of count+1. When bit 4 is 0 the counter runs freely.
- R6: `ovf_irq` is a one-cycle pulse, registered at the tick that wraps the count from 0xFFFF to 0. A clear-on-match reset does not raise it.
- R7: `match0`/`match1` are one-cycle pulses, registered at a tick where the count equals that channel's active compare value.
- R8: With control bit 5 (buffering) at 0, a committed compare write updates the active value and its buffer at the same edge.
- R9: With bit 5 at 1, a committed write changes only the buffer. The buffer is copied into the active value at each tick where the count equals the active value. When that copy and a write fall on the same edge, the active value takes the old buffer content.
- R10: Compare 0 sits at addresses 2 and 3, compare 1 at 4 and 5. A write with `bus_full`=1 commits all of `bus_wdata`. With `bus_full`=0, a write to the even address stores `bus_wdata[7:0]` in a staging register and commits nothing. A write to the odd address then commits {`bus_wdata[7:0]`, staged low part}.
- R11: After reset the count, the control word (including bit 5), both compare values, the buffers, the staging registers and all pulses are 0.
- R12: `rd_data` reads the control word at address 0 (bits 0,3:2,4,5 as written), active compare 0 at 2, active compare 1 at 4 and the count at 6. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tap_div1 | input | 1 | Prescaler enable, divide by 1 |
| tap_div4 | input | 1 | Prescaler enable, divide by 4 |
| tap_div16 | input | 1 | Prescaler enable, divide by 16 |
| ext_evt | input | 1 | Asynchronous external event level |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Write address |
| bus_full | input | 1 | 1 = full-width write, 0 = low/high part write |
| bus_wdata | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| match0 | output | 1 | Compare 0 match pulse |
| match1 | output | 1 | Compare 1 match pulse |
| ovf_irq | output | 1 | Overflow pulse |

## Verification
The bench targets the tick on which a shadow copy and a clear-on-match reset fall together. A design that copied the buffer one tick late would run one period at the old compare value. It also targets the wrap after 65,536 ticks, where an off-by-one or a missing gate would raise overflow on a clear-on-match reset too. It holds the event line high for many cycles, where a level-sensitive counter would run away. It sends a lone low-part write, after which a design without staging would show a half-updated compare value.

// File: rtl/evt_timer_pkg.sv
`timescale 1ns/1ps
package evt_timer_pkg;

   // register addresses (even = low part / full, odd = high part)
   localparam int unsigned REG_CTRL = 0;
   localparam int unsigned REG_CMP0 = 2;
   localparam int unsigned REG_CMP1 = 4;
   localparam int unsigned REG_CNT  = 6;

   // control word bit positions
   localparam int unsigned CB_RUN  = 0;
   localparam int unsigned CB_CLR  = 1;
   localparam int unsigned CB_SEL  = 2;
   localparam int unsigned CB_COM  = 4;
   localparam int unsigned CB_DBUF = 5;

   localparam int unsigned N_CMP = 2;

   typedef enum logic [1:0] {
      SEL_DIV1  = 2'd0,
      SEL_DIV4  = 2'd1,
      SEL_DIV16 = 2'd2,
      SEL_EXT   = 2'd3
   } clk_sel_e;

   typedef struct packed {
      logic     dbuf;
      logic     clr_on_match;
      clk_sel_e sel;
      logic     run;
   } ctrl_t;

endpackage

// File: rtl/evt_edge_sync.sv
`timescale 1ns/1ps
module evt_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic pulse
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("evt_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] pipe;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= '0;
         last <= 1'b0;
      end else begin
         pipe <= {pipe[STAGES-2:0], din};
         last <= pipe[STAGES-1];
      end
   end

   assign pulse = pipe[STAGES-1] & ~last;

endmodule

// File: rtl/evt_up_counter.sv
`timescale 1ns/1ps
module evt_up_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         clr,
   input  logic         clr_on_match,
   input  logic [W-1:0] limit,
   output logic [W-1:0] cnt,
   output logic         ovf
);

   localparam logic [W-1:0] TOP = '1;
   localparam logic [W-1:0] ONE = W'(1);

   logic hit;
   assign hit = clr_on_match && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else if (clr) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else if (tick) begin
         cnt <= hit ? '0 : cnt + ONE;
         ovf <= !hit && (cnt == TOP);
      end else begin
         ovf <= 1'b0;
      end
   end

endmodule

// File: rtl/evt_cmp_chan.sv
`timescale 1ns/1ps
module evt_cmp_chan #(
   parameter int             W    = 16,
   parameter int             AW   = 3,
   parameter logic [AW-1:0]  BASE = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic          full,
   input  logic [W-1:0]  wdata,
   input  logic          dbuf,
   input  logic          tick,
   input  logic          clr,
   input  logic [W-1:0]  cnt,
   output logic [W-1:0]  act,
   output logic [W-1:0]  buf_q,
   output logic          commit,
   output logic          xfer,
   output logic          match
);

   localparam int H = W / 2;

   logic [H-1:0] stage;
   logic         hit_addr;
   logic         stage_load;
   logic         eq;
   logic [W-1:0] newval;

   assign hit_addr   = wr && (addr[AW-1:1] == BASE[AW-1:1]);
   assign commit     = hit_addr && (full || addr[0]);
   assign stage_load = hit_addr && !full && !addr[0];
   assign newval     = full ? wdata : {wdata[H-1:0], stage};
   assign eq         = (cnt == act);
   assign xfer       = dbuf && tick && !clr && eq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage <= '0;
         buf_q <= '0;
         act   <= '0;
         match <= 1'b0;
      end else begin
         if (stage_load) stage <= wdata[H-1:0];
         if (commit) begin
            buf_q <= newval;
            if (!dbuf) act <= newval;
         end
         if (xfer) act <= buf_q;
         match <= tick && !clr && eq;
      end
   end

endmodule

// File: rtl/evt_timer16.sv
`timescale 1ns/1ps
module evt_timer16
   import evt_timer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tap_div1,
   input  logic              tap_div4,
   input  logic              tap_div16,
   input  logic              ext_evt,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_full,
   input  logic [CNT_W-1:0]  bus_wdata,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   output logic              match0,
   output logic              match1,
   output logic              ovf_irq
);

   generate
      if ((CNT_W % 2) != 0 || CNT_W < 8) begin : g_bad_width
         $error("evt_timer16: CNT_W must be even and at least 8");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("evt_timer16: ADDR_W must be at least 3");
      end
   endgenerate

   localparam int CTRL_W = $bits(ctrl_t) + 1;

   ctrl_t            ctrl;
   logic             ctrl_wr;
   logic             clr_now;
   logic             ext_pulse;
   logic [3:0]       src;
   logic             tick;
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;

   logic [CNT_W-1:0] act_v    [N_CMP];
   logic [CNT_W-1:0] buf_v    [N_CMP];
   logic             commit_v [N_CMP];
   logic             xfer_v   [N_CMP];
   logic             match_v  [N_CMP];

   // control register
   assign ctrl_wr = bus_wr && (bus_addr[ADDR_W-1:1] == '0);
   assign clr_now = ctrl_wr && bus_wdata[CB_CLR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (ctrl_wr) begin
         ctrl.run          <= bus_wdata[CB_RUN];
         ctrl.sel          <= clk_sel_e'(bus_wdata[CB_SEL +: 2]);
         ctrl.clr_on_match <= bus_wdata[CB_COM];
         ctrl.dbuf         <= bus_wdata[CB_DBUF];
      end
   end

   // count source
   evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ext_evt),
      .pulse (ext_pulse)
   );

   assign src  = {ext_pulse, tap_div16, tap_div4, tap_div1};
   assign tick = ctrl.run && src[ctrl.sel];

   evt_up_counter #(.W(CNT_W)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .clr          (clr_now),
      .clr_on_match (ctrl.clr_on_match),
      .limit        (act_v[1]),
      .cnt          (cnt_q),
      .ovf          (ovf_q)
   );

   // compare channels
   generate
      for (genvar ch = 0; ch < N_CMP; ch++) begin : g_chan
         evt_cmp_chan #(
            .W    (CNT_W),
            .AW   (ADDR_W),
            .BASE (ADDR_W'(REG_CMP0 + 2 * ch))
         ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (bus_wr),
            .addr   (bus_addr),
            .full   (bus_full),
            .wdata  (bus_wdata),
            .dbuf   (ctrl.dbuf),
            .tick   (tick),
            .clr    (clr_now),
            .cnt    (cnt_q),
            .act    (act_v[ch]),
            .buf_q  (buf_v[ch]),
            .commit (commit_v[ch]),
            .xfer   (xfer_v[ch]),
            .match  (match_v[ch])
         );
      end
   endgenerate

   // read port
   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_W'(REG_CTRL): rd_data = CNT_W'({ctrl.dbuf, ctrl.clr_on_match,
                                              ctrl.sel, 1'b0, ctrl.run});
         ADDR_W'(REG_CMP0): rd_data = act_v[0];
         ADDR_W'(REG_CMP1): rd_data = act_v[1];
         ADDR_W'(REG_CNT):  rd_data = cnt_q;
         default:           rd_data = '0;
      endcase
   end

   assign match0  = match_v[0];
   assign match1  = match_v[1];
   assign ovf_irq = ovf_q;

   logic [CTRL_W-1:0] unused_w;
   assign unused_w = '0;

endmodule

// File: rtl/evt_timer16_chk.sv
`timescale 1ns/1ps
module evt_timer16_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick,
   input logic         clr,
   input logic         com,
   input logic         dbuf,
   input logic [W-1:0] cnt,
   input logic [W-1:0] act0,
   input logic [W-1:0] act1,
   input logic [W-1:0] buf0,
   input logic         commit0,
   input logic         xfer0,
   input logic         match0,
   input logic         ovf
);

   // R6
   ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> cnt == '0);

   // R6
   ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> !ovf);

   // R5
   com_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clr && com && cnt == act1) |=> cnt == '0);

   // R1
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clr && !(com && cnt == act1)) |=> cnt == $past(cnt) + W'(1));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(cnt));

   // R4
   clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0);

   // R8
   mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit0 && !dbuf) |=> act0 == buf0);

   // R9
   shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit0 && dbuf && !xfer0) |=> $stable(act0));

   // R9
   xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer0 |=> act0 == $past(buf0));

   // R7
   match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match0 |-> $past(cnt) == $past(act0));

endmodule

bind evt_timer16 evt_timer16_chk #(.W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .clr     (clr_now),
   .com     (ctrl.clr_on_match),
   .dbuf    (ctrl.dbuf),
   .cnt     (cnt_q),
   .act0    (act_v[0]),
   .act1    (act_v[1]),
   .buf0    (buf_v[0]),
   .commit0 (commit_v[0]),
   .xfer0   (xfer_v[0]),
   .match0  (match_v[0]),
   .ovf     (ovf_q)
);

// File: tb/evt_timer16_test.sv
`timescale 1ns/1ps
module evt_timer16_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tap_div1 = 1'b0, tap_div4 = 1'b0, tap_div16 = 1'b0;
   logic        ext_evt = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_full = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        match0, match1, ovf_irq;

   int    errors = 0;
   int    checks = 0;
   int    cyc = 0;
   bit    done = 0;
   string cur_req = "R11";

   always #10 clk = ~clk;   // 50 MHz

   evt_timer16 uut (
      .clk(clk), .rst_n(rst_n), .tap_div1(tap_div1), .tap_div4(tap_div4),
      .tap_div16(tap_div16), .ext_evt(ext_evt), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_full(bus_full), .bus_wdata(bus_wdata),
      .rd_addr(rd_addr), .rd_data(rd_data), .match0(match0),
      .match1(match1), .ovf_irq(ovf_irq)
   );

   // ---------------- reference model ----------------
   int m_cnt, m_act[2], m_buf[2], m_stage[2], m_sel;
   bit m_run, m_com, m_dbuf, m_s1, m_s2, m_d, m_ovf;
   bit m_match[2];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_sel = 0; m_run = 0; m_com = 0; m_dbuf = 0;
         m_s1 = 0; m_s2 = 0; m_d = 0; m_ovf = 0;
         for (int i = 0; i < 2; i++) begin
            m_act[i] = 0; m_buf[i] = 0; m_stage[i] = 0; m_match[i] = 0;
         end
      end else begin
         bit pulse, tick, clr, hit;
         int nact[2], nbuf[2];
         pulse = m_s2 && !m_d;
         case (m_sel)
            0: tick = m_run && tap_div1;
            1: tick = m_run && tap_div4;
            2: tick = m_run && tap_div16;
            default: tick = m_run && pulse;
         endcase
         clr = bus_wr && (bus_addr < 2) && bus_wdata[1];
         hit = m_com && (m_cnt == m_act[1]);
         for (int i = 0; i < 2; i++) begin
            int base;
            base = 2 + 2 * i;
            nact[i] = m_act[i];
            nbuf[i] = m_buf[i];
            m_match[i] = tick && !clr && (m_cnt == m_act[i]);
            if (m_dbuf && tick && !clr && m_cnt == m_act[i]) nact[i] = m_buf[i];
            if (bus_wr && (bus_addr == base || bus_addr == base + 1)) begin
               int v;
               bit commit;
               commit = 0;
               if (bus_full) begin v = bus_wdata; commit = 1; end
               else if (bus_addr == base) begin m_stage[i] = bus_wdata[7:0]; v = 0; end
               else begin v = bus_wdata[7:0] * 256 + m_stage[i]; commit = 1; end
               if (commit) begin
                  nbuf[i] = v;
                  if (!m_dbuf) nact[i] = v;
               end
            end
         end
         if (clr) begin
            m_cnt = 0; m_ovf = 0;
         end else if (tick) begin
            m_ovf = !hit && (m_cnt == 65535);
            m_cnt = hit ? 0 : (m_cnt + 1) % 65536;
         end else m_ovf = 0;
         for (int i = 0; i < 2; i++) begin m_act[i] = nact[i]; m_buf[i] = nbuf[i]; end
         if (bus_wr && bus_addr < 2) begin
            m_run = bus_wdata[0]; m_sel = bus_wdata[3:2];
            m_com = bus_wdata[4]; m_dbuf = bus_wdata[5];
         end
         m_d = m_s2; m_s2 = m_s1; m_s1 = ext_evt;
      end
   end

   function automatic int m_read(int a);
      case (a)
         0: return m_dbuf * 32 + m_com * 16 + m_sel * 4 + m_run;
         2: return m_act[0];
         4: return m_act[1];
         6: return m_cnt;
         default: return 0;
      endcase
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // compare every cycle, between the input change and the next edge
   always @(negedge clk) begin
      #5;
      if (rst_n) begin
         check($sformatf("%s/R12 rd_data@%0d", cur_req, rd_addr), rd_data, m_read(rd_addr));
         check("R7 match0", match0, m_match[0]);
         check("R7 match1", match1, m_match[1]);
         check("R6 ovf_irq", ovf_irq, m_ovf);
      end
   end

   // prescaler taps and rotating read address
   always @(negedge clk) begin
      cyc++;
      tap_div1  = 1'b1;
      tap_div4  = (cyc % 4) == 0;
      tap_div16 = (cyc % 16) == 0;
      rd_addr   = 3'(cyc);
   end

   task automatic do_wr(int a, int d, bit full);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d); bus_full = full;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   function automatic int ctrl_word(bit run, bit clr, int sel, bit com, bit dbuf);
      return dbuf * 32 + com * 16 + sel * 4 + clr * 2 + run;
   endfunction

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      // R11: reset state
      idle(3);
      rst_n = 1'b1;
      idle(8);

      // R8: direct compare loads with buffering off
      cur_req = "R8";
      do_wr(2, 16'h0010, 1);
      do_wr(4, 16'h0020, 1);
      idle(8);

      // R5, R7: period timer on divide-by-1
      cur_req = "R5";
      do_wr(0, ctrl_word(1, 0, 0, 1, 0), 1);
      idle(120);

      // R9: shadowed update, new period takes effect on match
      cur_req = "R9";
      do_wr(0, ctrl_word(1, 0, 0, 1, 1), 1);
      do_wr(4, 16'h0030, 1);
      do_wr(2, 16'h0005, 1);
      idle(150);

      // R10: low part staged, committed only with high part
      cur_req = "R10";
      do_wr(0, ctrl_word(1, 0, 0, 1, 0), 1);
      do_wr(2, 16'h0034, 0);
      idle(10);
      do_wr(3, 16'h0000, 0);
      idle(10);
      do_wr(4, 16'h0040, 0);
      do_wr(5, 16'h0000, 0);
      idle(100);

      // R2: slower taps
      cur_req = "R2";
      do_wr(0, ctrl_word(1, 0, 1, 1, 0), 1);
      idle(300);
      do_wr(0, ctrl_word(1, 0, 2, 1, 0), 1);
      idle(700);

      // R3: external events with long high levels
      cur_req = "R3";
      do_wr(0, ctrl_word(1, 1, 3, 0, 0), 1);
      for (int k = 0; k < 12; k++) begin
         @(negedge clk) ext_evt = 1'b1;
         idle(9);
         @(negedge clk) ext_evt = 1'b0;
         idle(6);
      end
      idle(10);

      // R4: stop holds, clear zeroes and beats a tick
      cur_req = "R4";
      do_wr(0, ctrl_word(1, 0, 0, 0, 0), 1);
      idle(40);
      do_wr(0, ctrl_word(0, 0, 0, 0, 0), 1);
      idle(30);
      do_wr(0, ctrl_word(1, 1, 0, 0, 0), 1);
      idle(20);
      do_wr(0, ctrl_word(0, 1, 0, 0, 0), 1);
      idle(10);

      // R1, R6: free run through the wrap
      cur_req = "R1";
      do_wr(0, ctrl_word(1, 1, 0, 0, 0), 1);
      idle(65536 + 200);

      // R6: clear-on-match at all-ones must not raise overflow
      cur_req = "R6";
      do_wr(4, 16'hFFFF, 1);
      do_wr(0, ctrl_word(1, 1, 0, 1, 0), 1);
      idle(65536 + 100);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL all: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule